// File: doc/BRIEF.md
# SCL Bit-Timing Generator

This block paces the clock line of an I2C bus master. Three 32-bit timing words set its timing. Each word splits into an upper 16-bit length and a lower 16-bit offset. The first word gives the length of the released (high) SCL phase and the offset of a receive-sample strobe inside it. The second word gives the length of the driven-low SCL phase and the offset of a transmit-change strobe inside it. The third word gives the bus-free interval in its upper half and the start/stop hold time in its lower half. All lengths are counted in cycles of the reference clock, which runs at 24 MHz in the intended use.

A byte engine pulses `start_req` to open a transfer and `stop_req` to close it. The block drives SCL through an open-drain output (`scl_low` = 1 pulls the line low) and senses the real line level on `scl_in`. After the block releases SCL, the high-phase counter waits until the line is seen high. A slave that holds the line low therefore stretches the clock. The strobes let the data path sample SDA and change SDA at programmable points, not at the clock edges.

The controller has eight named states:

| State | Role |
|---|---|
| IDLE | Line released, not busy. |
| START_HOLD | Start hold, line released. |
| LOW | Low phase. |
| RISE | Released, waiting for the line to read high. |
| HIGH | High phase. |
| STOP_RISE | Released before a stop, waiting for the line to read high. |
| STOP_HOLD | Stop hold. |
| BUS_FREE | Bus-free wait. |

The transitions are:

| From | To | Condition |
|---|---|---|
| IDLE | START_HOLD | `start_req` |
| START_HOLD | LOW | Hold count done |
| LOW | RISE | Low count done, no stop pending |
| LOW | STOP_RISE | Low count done, stop pending |
| RISE | HIGH | `scl_in` high |
| HIGH | LOW | High count done |
| STOP_RISE | STOP_HOLD | `scl_in` high |
| STOP_HOLD | BUS_FREE | Hold count done |
| BUS_FREE | IDLE | Free count done |

Top module: `scl_tmg_gen`

## Requirements
- R1: After reset, register select 0 reads 0x0068004E, select 1 reads 0x00620018 and select 2 reads 0x00300030. These are the nominal settings for 100 kHz from 24 MHz. After reset `clk_busy` is 0 and `scl_low` is 0.
- R2: A write with `reg_we` high stores `reg_wdata` into the word picked by `reg_sel` (0 high word, 1 low word, 2 hold/free word). `reg_rdata` shows the selected word combinationally. Select 3 reads zero.
- R3: A `start_req` seen in IDLE raises `clk_busy` in the next cycle. SCL then stays released for exactly word2[15:0] cycles before it is driven low.
- R4: Each low phase drives `scl_low` for exactly word1[31:16] cycles. A length of 0 acts as 1.
- R5: `tx_change` is high for one cycle, on low-phase cycle index word1[15:0] (counting from 0). It does not fire when the offset is not below the length.
- R6: After a low phase SCL is released. The high counter starts the cycle after `scl_in` reads high. An unstretched released interval therefore lasts word0[31:16]+1 cycles, and `rx_sample` fires once at index word0[15:0]+1 of that interval.
- R7: While `scl_in` stays low after release, the high counter does not advance and `rx_sample` stays low. The strobe keeps its position relative to the moment the line is seen high.
- R8: A `stop_req` taken during an active transfer ends the transfer after the next low phase completes. SCL is released, the block waits for the line to read high, and it then holds for word2[15:0] cycles. `clk_busy` is high for 1+word2[15:0] cycles after the last low cycle and then falls, with SCL released.
- R9: After `clk_busy` falls, the block waits word2[31:16] cycles in BUS_FREE and ignores `start_req` during that wait. It then returns to IDLE and accepts a new start.
- R10: `start_req` has no effect while a transfer is active, and `stop_req` has no effect in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Timing word write strobe |
| reg_sel | input | 2 | Timing word select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Selected timing word |
| start_req | input | 1 | Open a transfer |
| stop_req | input | 1 | Close the transfer after the next low phase |
| scl_in | input | 1 | Sensed SCL line level |
| scl_low | output | 1 | Pull SCL low when 1 |
| rx_sample | output | 1 | One-cycle SDA sample strobe in the high phase |
| tx_change | output | 1 | One-cycle SDA change strobe in the low phase |
| clk_busy | output | 1 | Clock generator busy, from start until the stop hold ends |

## Verification
A wrong state or a misloaded counter shows up at the ports within one phase. A phase that is too short or too long changes the measured run length of `scl_low` at once. A strobe at the wrong index, or two strobes, is visible inside the same phase. A stop-pending flag that is lost or stuck shows as `clk_busy` never falling, or falling one full bit early. A broken wait in RISE shows as `rx_sample` firing while the bench is still holding the line low.

// File: rtl/scl_tmg_pkg.sv
package scl_tmg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START_HOLD,
        ST_LOW,
        ST_RISE,
        ST_HIGH,
        ST_STOP_RISE,
        ST_STOP_HOLD,
        ST_BUS_FREE
    } tmg_state_e;

    // Nominal half-period base for a given reference and bus rate
    function automatic int unsigned nom_base(input int unsigned ref_hz, input int unsigned bus_hz);
        return ((ref_hz / bus_hz) - 38) / 2;
    endfunction

    // High word: high length above, sample offset (3/4 of length) below
    function automatic logic [31:0] nom_high_word(input int unsigned ref_hz, input int unsigned bus_hz);
        int unsigned hi;
        hi = nom_base(ref_hz, bus_hz) + 3;
        return {hi[15:0], 16'((hi * 3) / 4)};
    endfunction

    // Low word: low length above, change offset (1/4 of length) below
    function automatic logic [31:0] nom_low_word(input int unsigned ref_hz, input int unsigned bus_hz);
        int unsigned lo;
        lo = nom_base(ref_hz, bus_hz) - 3;
        return {lo[15:0], 16'(lo / 4)};
    endfunction

endpackage

// File: rtl/scl_tmg_regs.sv
module scl_tmg_regs #(
    parameter int          HALF_W = 16,
    parameter logic [31:0] INIT0  = 32'h0,
    parameter logic [31:0] INIT1  = 32'h0,
    parameter logic [31:0] INIT2  = 32'h0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [1:0]          sel,
    input  logic [2*HALF_W-1:0] wdata,
    output logic [2*HALF_W-1:0] word0,
    output logic [2*HALF_W-1:0] word1,
    output logic [2*HALF_W-1:0] word2,
    output logic [2*HALF_W-1:0] rdata
);
    localparam int REG_W = 2 * HALF_W;
    localparam int NREG  = 3;

    logic [REG_W-1:0] words [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_word
        localparam logic [31:0] INIT = (i == 0) ? INIT0 : (i == 1) ? INIT1 : INIT2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                words[i] <= INIT[REG_W-1:0];
            else if (we && (sel == 2'(i)))
                words[i] <= wdata;
        end
    end

    assign word0 = words[0];
    assign word1 = words[1];
    assign word2 = words[2];

    always_comb begin
        unique case (sel)
            2'd0:    rdata = words[0];
            2'd1:    rdata = words[1];
            2'd2:    rdata = words[2];
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/scl_tmg_fsm.sv
module scl_tmg_fsm
    import scl_tmg_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_req,
    input  logic          stop_req,
    input  logic          scl_in,
    input  logic [CW-1:0] hi_len,
    input  logic [CW-1:0] rx_off,
    input  logic [CW-1:0] lo_len,
    input  logic [CW-1:0] tx_off,
    input  logic [CW-1:0] hold_len,
    input  logic [CW-1:0] free_len,
    output logic          scl_low,
    output logic          rx_sample,
    output logic          tx_change,
    output logic          clk_busy
);
    tmg_state_e    state, nxt;
    logic [CW-1:0] cnt, cur_len;
    logic          stop_pend, last, active;

    always_comb begin
        unique case (state)
            ST_START_HOLD, ST_STOP_HOLD: cur_len = hold_len;
            ST_LOW:                      cur_len = lo_len;
            ST_HIGH:                     cur_len = hi_len;
            ST_BUS_FREE:                 cur_len = free_len;
            default:                     cur_len = '0;
        endcase
    end

    // Length 0 acts as 1: the phase ends when cnt+1 reaches the length
    assign last   = ({1'b0, cnt} + {{CW{1'b0}}, 1'b1}) >= {1'b0, cur_len};
    assign active = (state == ST_START_HOLD) || (state == ST_LOW) ||
                    (state == ST_RISE) || (state == ST_HIGH);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:       if (start_req) nxt = ST_START_HOLD;
            ST_START_HOLD: if (last)      nxt = ST_LOW;
            ST_LOW:        if (last)      nxt = stop_pend ? ST_STOP_RISE : ST_RISE;
            ST_RISE:       if (scl_in)    nxt = ST_HIGH;
            ST_HIGH:       if (last)      nxt = ST_LOW;
            ST_STOP_RISE:  if (scl_in)    nxt = ST_STOP_HOLD;
            ST_STOP_HOLD:  if (last)      nxt = ST_BUS_FREE;
            ST_BUS_FREE:   if (last)      nxt = ST_IDLE;
            default:                      nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            stop_pend <= 1'b0;
        end else begin
            state <= nxt;
            cnt   <= (nxt != state) ? '0 : cnt + 1'b1;
            if (nxt == ST_STOP_RISE && state != ST_STOP_RISE)
                stop_pend <= 1'b0;
            else if (stop_req && active)
                stop_pend <= 1'b1;
        end
    end

    always_comb begin
        scl_low   = (state == ST_LOW);
        tx_change = (state == ST_LOW)  && (cnt == tx_off);
        rx_sample = (state == ST_HIGH) && (cnt == rx_off);
        clk_busy  = (state != ST_IDLE) && (state != ST_BUS_FREE);
    end
endmodule

// File: rtl/scl_tmg_gen.sv
module scl_tmg_gen
    import scl_tmg_pkg::*;
#(
    parameter int unsigned REF_HZ   = 24_000_000,
    parameter int unsigned BUS_HZ   = 100_000,
    parameter int          HALF_W   = 16,
    parameter logic [31:0] HOLD_INIT = 32'h0030_0030
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [1:0]          reg_sel,
    input  logic [2*HALF_W-1:0] reg_wdata,
    output logic [2*HALF_W-1:0] reg_rdata,
    input  logic                start_req,
    input  logic                stop_req,
    input  logic                scl_in,
    output logic                scl_low,
    output logic                rx_sample,
    output logic                tx_change,
    output logic                clk_busy
);
    localparam int REG_W = 2 * HALF_W;

    logic [REG_W-1:0] word0, word1, word2;

    scl_tmg_regs #(
        .HALF_W (HALF_W),
        .INIT0  (nom_high_word(REF_HZ, BUS_HZ)),
        .INIT1  (nom_low_word(REF_HZ, BUS_HZ)),
        .INIT2  (HOLD_INIT)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .sel   (reg_sel),
        .wdata (reg_wdata),
        .word0 (word0),
        .word1 (word1),
        .word2 (word2),
        .rdata (reg_rdata)
    );

    scl_tmg_fsm #(.CW(HALF_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .stop_req  (stop_req),
        .scl_in    (scl_in),
        .hi_len    (word0[REG_W-1:HALF_W]),
        .rx_off    (word0[HALF_W-1:0]),
        .lo_len    (word1[REG_W-1:HALF_W]),
        .tx_off    (word1[HALF_W-1:0]),
        .hold_len  (word2[HALF_W-1:0]),
        .free_len  (word2[REG_W-1:HALF_W]),
        .scl_low   (scl_low),
        .rx_sample (rx_sample),
        .tx_change (tx_change),
        .clk_busy  (clk_busy)
    );
endmodule

// File: rtl/scl_tmg_chk.sv
module scl_tmg_chk (
    input logic clk,
    input logic rst_n,
    input logic start_req,
    input logic scl_low,
    input logic rx_sample,
    input logic tx_change,
    input logic clk_busy
);
    a_r3_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_busy) |-> ($past(start_req) && !scl_low));

    a_r8_released_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_busy) |-> !scl_low);

    a_r5_tx_only_low: assert property (@(posedge clk) disable iff (!rst_n)
        tx_change |-> (scl_low && clk_busy));

    a_r6_rx_only_high: assert property (@(posedge clk) disable iff (!rst_n)
        rx_sample |-> (!scl_low && clk_busy));

    a_r5_tx_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        tx_change |=> !tx_change);

    a_r6_rx_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rx_sample |=> !rx_sample);

    a_r4_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_sample && tx_change));
endmodule

bind scl_tmg_gen scl_tmg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .scl_low   (scl_low),
    .rx_sample (rx_sample),
    .tx_change (tx_change),
    .clk_busy  (clk_busy)
);

// File: tb/test_scl_tmg_gen.sv
`timescale 1ns/1ps
module test_scl_tmg_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        start_req = 1'b0;
    logic        stop_req = 1'b0;
    logic        stretch = 1'b0;
    logic        scl_in;
    logic        scl_low, rx_sample, tx_change, clk_busy;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    // Open-drain line: low when the block pulls or a slave stretches
    assign scl_in = ~scl_low & ~stretch;

    scl_tmg_gen i_scl_tmg_gen (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .start_req(start_req),
        .stop_req(stop_req), .scl_in(scl_in), .scl_low(scl_low),
        .rx_sample(rx_sample), .tx_change(tx_change), .clk_busy(clk_busy)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] d);
        reg_sel = s;
        #1 d = reg_rdata;
    endtask

    // Measure one run of scl_low at level lvl with its strobe position
    task automatic meas(input logic lvl, output int len, output int idx, output int ns);
        int g = 0;
        len = 0; idx = -1; ns = 0;
        while (scl_low !== lvl && g < 1000) begin g++; @(negedge clk); end
        while (scl_low === lvl && len < 1000) begin
            if (lvl ? tx_change : rx_sample) begin idx = len; ns++; end
            len++;
            @(negedge clk);
        end
    endtask

    task automatic begin_frame(output int hold);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        hold = 0;
        while (!scl_low && hold < 1000) begin hold++; @(negedge clk); end
    endtask

    task automatic end_frame(output int tail);
        int len, idx, ns;
        stop_req = 1'b1;
        meas(1'b1, len, idx, ns);
        stop_req = 1'b0;
        tail = 0;
        while (clk_busy && tail < 1000) begin tail++; @(negedge clk); end
        repeat (4) @(negedge clk);
    endtask

    task automatic program_small();
        wr(2'd0, {16'd6, 16'd4});
        wr(2'd1, {16'd5, 16'd1});
        wr(2'd2, {16'd2, 16'd3});
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(2'd0, d); chk("R1 word0 reset", d, 32'h0068004E);
        rd(2'd1, d); chk("R1 word1 reset", d, 32'h00620018);
        rd(2'd2, d); chk("R1 word2 reset", d, 32'h00300030);
        chk("R1 busy reset", clk_busy, 0);
        chk("R1 scl reset", scl_low, 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        @(negedge clk);
        wr(2'd0, 32'hA5A5_1234); rd(2'd0, d); chk("R2 word0 write", d, 32'hA5A5_1234);
        wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, d); chk("R2 select 3 reads zero", d, 0);
        program_small();
        rd(2'd1, d); chk("R2 word1 write", d, {16'd5, 16'd1});
        rd(2'd2, d); chk("R2 word2 write", d, {16'd2, 16'd3});
    endtask

    task automatic t_frame();
        int hold, len, idx, ns, tail, bad;
        begin_frame(hold);
        chk("R3 start hold length", hold, 3);
        meas(1'b1, len, idx, ns);
        chk("R4 low length", len, 5);
        chk("R5 tx index", idx, 1);
        chk("R5 tx count", ns, 1);
        meas(1'b0, len, idx, ns);
        chk("R6 released length", len, 7);
        chk("R6 rx index", idx, 5);
        chk("R6 rx count", ns, 1);
        start_req = 1'b1;
        meas(1'b1, len, idx, ns);
        start_req = 1'b0;
        chk("R10 start ignored while busy", len, 5);
        meas(1'b0, len, idx, ns);
        stop_req = 1'b1;
        meas(1'b1, len, idx, ns);
        stop_req = 1'b0;
        tail = 0; bad = 0;
        while (clk_busy && tail < 1000) begin
            if (scl_low) bad++;
            tail++;
            @(negedge clk);
        end
        chk("R8 busy tail after last low", tail, 4);
        chk("R8 line released at stop", bad, 0);
        // Now in the first bus-free cycle: a start here must be ignored
        start_req = 1'b1;
        @(negedge clk); @(negedge clk);
        start_req = 1'b0;
        bad = 0;
        repeat (5) begin if (clk_busy || scl_low) bad++; @(negedge clk); end
        chk("R9 start ignored during bus free", bad, 0);
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        bad = 0;
        repeat (4) begin if (clk_busy || scl_low) bad++; @(negedge clk); end
        chk("R10 stop ignored in idle", bad, 0);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        chk("R9 start accepted after bus free", clk_busy, 1);
        while (!scl_low) @(negedge clk);
        end_frame(tail);
    endtask

    task automatic t_stretch();
        int hold, len, idx, ns, tail, bad, held;
        begin_frame(hold);
        meas(1'b1, len, idx, ns);
        stretch = 1'b1;
        bad = 0; held = 0;
        repeat (10) begin
            @(negedge clk);
            if (rx_sample) bad++;
            if (scl_low) held++;
        end
        stretch = 1'b0;
        chk("R7 no rx while stretched", bad, 0);
        chk("R7 block keeps line released", held, 0);
        meas(1'b0, len, idx, ns);
        chk("R7 released run after stretch", len, 7);
        chk("R7 rx index after stretch", idx, 5);
        end_frame(tail);
        chk("R8 busy ends after stretched frame", clk_busy, 0);
    endtask

    task automatic t_offsets();
        int hold, len, idx, ns, tail;
        wr(2'd1, {16'd0, 16'd0});
        wr(2'd0, {16'd6, 16'd0});
        begin_frame(hold);
        meas(1'b1, len, idx, ns);
        chk("R4 zero length acts as one", len, 1);
        chk("R5 tx at index 0", idx, 0);
        meas(1'b0, len, idx, ns);
        chk("R6 rx offset 0 index", idx, 1);
        end_frame(tail);
        wr(2'd1, {16'd5, 16'd7});
        begin_frame(hold);
        meas(1'b1, len, idx, ns);
        chk("R5 offset beyond length gives no tx", ns, 0);
        chk("R4 low length 5", len, 5);
        end_frame(tail);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_frame();
        t_stretch();
        t_offsets();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule